// File: doc/BRIEF.md
# One-Time-Programmable Memory Mode Control and Identification

This block is a synchronous behavioural model of the control side of a byte-wide one-time-programmable memory. On each clock edge it samples active-low chip select, output enable and program strobe, plus two level flags: one for a raised programming supply and one for a high voltage on address line 9. From these it picks one of eight operating modes. It then either drives array data, drives an identification byte, floats the bus, or writes the presented byte into the array. An erased array holds all ones. Programming can only clear bits, because each write ANDs the input byte into the stored byte.

The full-size part has an 18-bit address. The default address width here is 11 so that the modelled array stays small; address line 9 is a parameter. Access delays are counted in clock edges. The address or chip-select access delay is `T_ACC`, and the shorter output-enable access delay is `T_OE`. The bus carries data only after both delays have run out.

Read data leaves the block as `rd_data` qualified by `rd_valid`. This path has no ready input and no back-pressure. A sink captures the byte in any cycle where `rd_valid` is high. The byte stays constant for as long as the pins stay constant. When `rd_valid` is low the bus counts as high-impedance, and `rd_data` reads zero. Program data enters on `din` with no handshake. The write strobe is the program mode itself.

Top module: `otp_rom_ctrl`

## Requirements
- R1: After reset: `rd_valid`=0, `rd_data`=0, `id_err`=0 and `mode`=0. Every array byte reads 0xFF.
- R2: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `a9_hv`=0, the block drives the byte stored at `addr`.
  - Edge counting: edge 1 is the first edge that samples a changed address or a newly low `ce_n`. `rd_valid` rises at edge `T_ACC`+1.
  - Likewise, `rd_valid` rises at edge `T_OE`+1 after the first edge that samples `oe_n` low.
  - When both delays are running, the later of the two governs. The edge before it still shows `rd_valid`=0.
- R3: When `ce_n`=1 and `vpp_hi`=0, the mode is standby (code 0). `rd_valid` is 0 from the first edge that samples this, whatever `oe_n` is.
- R4: When `ce_n`=0, `oe_n`=1 and `vpp_hi`=0, the mode is output-disable (code 1). `rd_valid`=0.
- R5: When `vpp_hi`=1, `ce_n`=0, `pgm_n`=0 and `oe_n`=1, the mode is program (code 4). Each such edge stores (old AND `din`) at `addr`. `rd_valid`=0.
- R6: No write happens in two cases, and in both `rd_valid`=0:
  - `vpp_hi`=1 with `ce_n`=1: program-inhibit (code 6).
  - `vpp_hi`=1, `ce_n`=0, `oe_n`=0 and `pgm_n`=0: program-idle (code 7).
- R7: When `vpp_hi`=1, `ce_n`=0, `oe_n`=0 and `pgm_n`=1, the mode is verify (code 5). The stored byte is driven with the timing of R2.
- R8: When `a9_hv`=1 with the read conditions of R2, the mode is identification (code 3). The byte driven depends on the low address bits:
  - `addr[1]`=1, `addr[0]`=0: 0x1C.
  - `addr[1]`=1, `addr[0]`=1: 0x02.
  - `addr[1]`=0: 0x7F.
- R9: Every identification byte has an odd number of ones, with bit 7 acting as the parity bit.
- R10: `id_err` is 1 one edge after an identification-mode sample in which some address bit other than bits 0, 1 and 9 is high. Otherwise it is 0.
- R11: `rd_valid` falls at the first edge that samples `ce_n` or `oe_n` high, whichever of the two rises first.
- R12: A bit that has been programmed to 0 stays 0 when a later write presents 1 in that position.
- R13: `mode` shows, one edge after sampling, the code of the mode decoded from the pins: 0 standby, 1 output-disable, 2 read, 3 identification, 4 program, 5 verify, 6 program-inhibit, 7 program-idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; erases the array model |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hv | input | 1 | High voltage present on address line 9 |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program |
| rd_data | output | 8 | Driven byte; zero while floating |
| rd_valid | output | 1 | Bus driven with valid data |
| mode | output | 3 | Registered operating-mode code |
| id_err | output | 1 | Illegal address during identification |

## Verification
Two things can land on the same edge: the address-access timer restarting, and output enable falling after a pause. Either one alone sets when `rd_valid` rises. The bench raises `oe_n` while reading, then lowers it on the same edge that the address changes. It checks that `rd_valid` is still low at edge `T_OE`+1 and rises only at edge `T_ACC`+1, carrying the new location's byte. The same pairing is checked for the output-float case, with chip select and output enable rising on one edge. It is also checked for an identification read that carries an illegal address bit: the byte and `id_err` must both appear.

// File: rtl/otp_ctl_pkg.sv
package otp_ctl_pkg;

  typedef enum logic [2:0] {
    M_STANDBY = 3'd0,
    M_ODIS    = 3'd1,
    M_READ    = 3'd2,
    M_IDENT   = 3'd3,
    M_PROG    = 3'd4,
    M_VERIFY  = 3'd5,
    M_INHIBIT = 3'd6,
    M_PIDLE   = 3'd7
  } op_mode_e;

  // Prefix a 7-bit code with a bit that makes the total count of ones odd.
  function automatic logic [7:0] odd_parity_byte(input logic [6:0] code);
    return {~(^code), code};
  endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_ctl_pkg::*;
(
  input  logic     ce_n,
  input  logic     oe_n,
  input  logic     pgm_n,
  input  logic     vpp_hi,
  input  logic     a9_hv,
  output op_mode_e mode,
  output logic     wr_en,
  output logic     drives_bus
);

  always_comb begin
    if (ce_n) begin
      mode = vpp_hi ? M_INHIBIT : M_STANDBY;
    end else if (vpp_hi) begin
      if (!pgm_n && oe_n)      mode = M_PROG;
      else if (pgm_n && !oe_n) mode = M_VERIFY;
      else                     mode = M_PIDLE;
    end else if (oe_n) begin
      mode = M_ODIS;
    end else begin
      mode = a9_hv ? M_IDENT : M_READ;
    end
  end

  assign wr_en      = (mode == M_PROG);
  assign drives_bus = (mode == M_READ) || (mode == M_VERIFY) || (mode == M_IDENT);

endmodule

// File: rtl/otp_access_timer.sv
module otp_access_timer #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic done
);

  localparam int CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    if (restart)           cnt_nxt = '0;
    else if (cnt_q >= LIM) cnt_nxt = LIM;
    else                   cnt_nxt = cnt_q + CW'(1);
  end

  // done reflects the count this edge lands on, so the output stage can
  // register data in the same edge the delay expires.
  assign done = (cnt_nxt >= LIM);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= LIM;
    else     cnt_q <= cnt_nxt;
  end

  // R2
  restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0));

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  assign rd_data = mem_q[addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (wr_en) begin
      mem_q[addr] <= mem_q[addr] & wr_data;
    end
  end

  // R12
  no_zero_to_one_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((mem_q[$past(addr)] & ~$past(mem_q[addr])) == 8'h00));

endmodule

// File: rtl/otp_id_codes.sv
module otp_id_codes
  import otp_ctl_pkg::*;
#(
  parameter logic [6:0] MFR_CODE  = 7'h1C,
  parameter logic [6:0] DEV_CODE  = 7'h02,
  parameter logic [6:0] CONT_CODE = 7'h7F
) (
  input  logic       sel_pair,
  input  logic       sel_dev,
  output logic [7:0] id_byte
);

  localparam logic [7:0] MFR_B  = odd_parity_byte(MFR_CODE);
  localparam logic [7:0] DEV_B  = odd_parity_byte(DEV_CODE);
  localparam logic [7:0] CONT_B = odd_parity_byte(CONT_CODE);

  always_comb begin
    if (!sel_pair)    id_byte = CONT_B;
    else if (sel_dev) id_byte = DEV_B;
    else              id_byte = MFR_B;
  end

  // R9
  id_parity_odd_chk: assert final (^id_byte == 1'b1);

endmodule

// File: rtl/otp_rom_ctrl.sv
module otp_rom_ctrl
  import otp_ctl_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int HV_BIT = 9,
  parameter int T_ACC  = 3,
  parameter int T_OE   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic [2:0]        mode,
  output logic              id_err
);

  localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ID_FREE = (ONE << HV_BIT) | (ONE << 1) | ONE;

  op_mode_e          mode_nxt;
  op_mode_e          mode_q;
  logic              wr_en;
  logic              drives_bus;
  logic              ce_prev_n;
  logic              oe_prev_n;
  logic [ADDR_W-1:0] addr_prev;
  logic              acc_done;
  logic              oe_done;
  logic [7:0]        cell_byte;
  logic [7:0]        id_byte;
  logic              drive_nxt;
  logic              bad_id_addr;

  otp_mode_decode u_dec (
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .pgm_n      (pgm_n),
    .vpp_hi     (vpp_hi),
    .a9_hv      (a9_hv),
    .mode       (mode_nxt),
    .wr_en      (wr_en),
    .drives_bus (drives_bus)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_prev_n <= 1'b1;
      oe_prev_n <= 1'b1;
      addr_prev <= '0;
    end else begin
      ce_prev_n <= ce_n;
      oe_prev_n <= oe_n;
      addr_prev <= addr;
    end
  end

  otp_access_timer #(.LIMIT(T_ACC)) u_acc_tmr (
    .clk     (clk),
    .rst     (rst),
    .restart (ce_n || ce_prev_n || (addr != addr_prev)),
    .done    (acc_done)
  );

  otp_access_timer #(.LIMIT(T_OE)) u_oe_tmr (
    .clk     (clk),
    .rst     (rst),
    .restart (oe_n || oe_prev_n),
    .done    (oe_done)
  );

  otp_cell_array #(.ADDR_W(ADDR_W)) u_cells (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (din),
    .rd_data (cell_byte)
  );

  otp_id_codes u_ids (
    .sel_pair (addr[1]),
    .sel_dev  (addr[0]),
    .id_byte  (id_byte)
  );

  assign drive_nxt   = drives_bus && acc_done && oe_done;
  assign bad_id_addr = |(addr & ~ID_FREE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_STANDBY;
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
      id_err   <= 1'b0;
    end else begin
      mode_q   <= mode_nxt;
      rd_valid <= drive_nxt;
      if (!drive_nxt)              rd_data <= 8'h00;
      else if (mode_nxt == M_IDENT) rd_data <= id_byte;
      else                          rd_data <= cell_byte;
      id_err   <= (mode_nxt == M_IDENT) && bad_id_addr;
    end
  end

  assign mode = mode_q;

  // R11
  float_on_ce_chk: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !rd_valid);

  // R11
  float_on_oe_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> !rd_valid);

  // R9
  id_out_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && (mode_q == M_IDENT)) |-> (^rd_data == 1'b1));

  // R10
  id_err_mode_chk: assert property (@(posedge clk) disable iff (rst)
    id_err |-> (mode_q == M_IDENT));

  // R5
  no_drive_in_prog_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_PROG) |-> !rd_valid);

endmodule

// File: tb/tb_otp_rom_ctrl.sv
`timescale 1ns/1ps
module tb_otp_rom_ctrl;

  localparam int ADDR_W = 11;
  localparam int T_ACC  = 3;
  localparam int T_OE   = 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
  logic              vpp_hi = 1'b0, a9_hv = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        din = 8'hFF;
  logic [7:0]        rd_data;
  logic              rd_valid;
  logic [2:0]        mode;
  logic              id_err;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  otp_rom_ctrl #(.ADDR_W(ADDR_W), .T_ACC(T_ACC), .T_OE(T_OE)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .a9_hv(a9_hv), .addr(addr), .din(din),
    .rd_data(rd_data), .rd_valid(rd_valid), .mode(mode), .id_err(id_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pins(input logic c, input logic o, input logic p, input logic v,
                      input logic h, input logic [ADDR_W-1:0] a, input logic [7:0] d);
    ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; a9_hv = h; addr = a; din = d;
  endtask

  // Leave standby, start a plain read, check the byte at the access edge.
  task automatic read_check(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string tag);
    pins(1, 1, 1, 0, 0, a, 8'hFF);
    edges(1);
    pins(0, 0, 1, 0, 0, a, 8'hFF);
    edges(T_ACC);
    check({tag, " not yet valid"}, rd_valid, 0);
    edges(1);
    check({tag, " valid"}, rd_valid, 1);
    check({tag, " data"}, rd_data, exp);
  endtask

  task automatic t_reset;
    check("R1 rd_valid", rd_valid, 0);
    check("R1 rd_data", rd_data, 0);
    check("R1 id_err", id_err, 0);
    check("R13 R1 mode standby", mode, 0);
    read_check(ADDR_W'(2047), 8'hFF, "R1 erased top");
    check("R13 mode read", mode, 2);
  endtask

  task automatic t_timing;
    read_check(ADDR_W'(5), 8'hFF, "R2 ce access");
    // output enable alone
    pins(0, 1, 1, 0, 0, ADDR_W'(5), 8'hFF);
    edges(1);
    check("R4 float", rd_valid, 0);
    check("R13 mode odis", mode, 1);
    pins(0, 0, 1, 0, 0, ADDR_W'(5), 8'hFF);
    edges(T_OE);
    check("R2 oe not yet", rd_valid, 0);
    edges(1);
    check("R2 oe access", rd_valid, 1);
    // oe fall and address change on the same edge: the longer delay governs
    pins(0, 1, 1, 0, 0, ADDR_W'(5), 8'hFF);
    edges(1);
    pins(0, 0, 1, 0, 0, ADDR_W'(6), 8'hFF);
    edges(T_OE + 1);
    check("R2 addr delay dominates", rd_valid, 0);
    edges(T_ACC - T_OE);
    check("R2 both done", rd_valid, 1);
  endtask

  task automatic t_float;
    pins(1, 0, 1, 0, 0, ADDR_W'(6), 8'hFF);
    edges(1);
    check("R3 R11 standby float", rd_valid, 0);
    check("R13 R3 mode", mode, 0);
    read_check(ADDR_W'(6), 8'hFF, "R2 reread");
    pins(1, 1, 1, 0, 0, ADDR_W'(6), 8'hFF);
    edges(1);
    check("R11 both rise", rd_valid, 0);
  endtask

  task automatic t_program;
    pins(0, 1, 0, 1, 0, ADDR_W'(10), 8'hA5);
    edges(2);
    check("R5 no drive", rd_valid, 0);
    check("R13 R5 mode prog", mode, 4);
    pins(0, 0, 1, 1, 0, ADDR_W'(10), 8'hFF);
    edges(T_OE);
    check("R7 not yet", rd_valid, 0);
    edges(1);
    check("R7 verify valid", rd_valid, 1);
    check("R7 verify data", rd_data, 8'hA5);
    check("R13 R7 mode verify", mode, 5);
    // ones over zeros stay zero
    pins(0, 1, 0, 1, 0, ADDR_W'(10), 8'hF0);
    edges(1);
    pins(0, 0, 1, 1, 0, ADDR_W'(10), 8'hFF);
    edges(T_OE + 1);
    check("R12 only clears", rd_data, 8'hA0);
    read_check(ADDR_W'(10), 8'hA0, "R12 normal read");
  endtask

  task automatic t_inhibit;
    pins(1, 1, 0, 1, 0, ADDR_W'(20), 8'h00);
    edges(3);
    check("R6 inhibit float", rd_valid, 0);
    check("R13 R6 mode inhibit", mode, 6);
    pins(0, 0, 0, 1, 0, ADDR_W'(20), 8'h00);
    edges(T_ACC + 2);
    check("R6 idle float", rd_valid, 0);
    check("R13 R6 mode idle", mode, 7);
    read_check(ADDR_W'(20), 8'hFF, "R6 untouched");
  endtask

  task automatic id_read(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input logic err,
                         input string tag);
    pins(0, 0, 1, 0, 1, a, 8'hFF);
    edges(T_ACC + 1);
    check({tag, " valid"}, rd_valid, 1);
    check({tag, " byte"}, rd_data, exp);
    check("R9 odd parity", ^rd_data, 1);
    check("R10 err flag", id_err, err);
    check("R13 R8 mode ident", mode, 3);
  endtask

  task automatic t_ident;
    pins(1, 1, 1, 0, 1, ADDR_W'(0), 8'hFF);
    edges(1);
    id_read(ADDR_W'(2), 8'h1C, 0, "R8 maker");
    id_read(ADDR_W'(3), 8'h02, 0, "R8 device");
    id_read(ADDR_W'(0), 8'h7F, 0, "R8 cont a0 low");
    id_read(ADDR_W'(1), 8'h7F, 0, "R8 cont a0 high");
    id_read(ADDR_W'(2) | ADDR_W'(32), 8'h1C, 1, "R10 bad bit5");
    id_read(ADDR_W'(3) | ADDR_W'(512), 8'h02, 0, "R10 bit9 allowed");
    id_read(ADDR_W'(2) | ADDR_W'(1024), 8'h1C, 1, "R10 bad bit10");
    read_check(ADDR_W'(32), 8'hFF, "R10 plain read");
    check("R10 no err outside ident", id_err, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    edges(3);
    rst = 1'b0;
    edges(1);
    t_reset();
    t_timing();
    t_float();
    t_program();
    t_inhibit();
    t_ident();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule